// File: doc/BRIEF.md
# Ethernet Transmit Pause Controller

This block sits between a control register file and a byte-wide Ethernet transmit datapath. Software issues single-cycle command pulses: enable transmission, halt transmission, send a flow-control pause frame carrying a programmed quantum, or send a pause frame whose quantum is zero. The block schedules each command against the frame currently on the wire. Ordinary data frames are passed through from an upstream byte source. Pause frames are built internally, byte by byte, and handed to the transmitter. The frame check sequence is appended further downstream.

When flow control is enabled, a valid pause frame reported by the receiver loads a hold-off timer. While the timer runs, no new data frame is started. In half-duplex operation, carrier sense and collision block the start of any frame, and receiving is not allowed while a frame is being sent. In full-duplex operation both sensing inputs are ignored, and receiving stays allowed throughout.

Top module: `tx_pause_ctrl`

## Requirements
- R1: After reset, `tx_valid` and `tx_enabled` are 0, `pause_hold` is 0, `rx_allowed` is 1, and no frame is started.
- R2: A pulse on `cmd_start` sets `tx_enabled`. While it is set, each upstream data frame is forwarded unchanged, byte for byte, with `tx_last` on its final byte.
- R3: A pulse on `cmd_halt` never truncates a data frame in progress. The frame completes, then `tx_enabled` clears, and no further data frame starts until the next `cmd_start`.
- R4: A pause frame is exactly 60 bytes, with `tx_last` on byte 59. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `station_addr`, most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 carry the quantum, high byte first. Bytes 18-59 are zero.
- R5: A pulse on `cmd_pause` sends one pause frame whose quantum is `pause_quanta_cfg`. A pulse on `cmd_zero_pause` sends one pause frame with quantum 0.
- R6: A pending pause request waits until no frame is in progress, then goes ahead of any waiting data frame. It is gated neither by `tx_enabled` nor by `pause_hold`.
- R7: If both pause requests are pending together, the zero-quantum frame is sent first and the programmed one second. Each request yields exactly one frame.
- R8: With `pause_en` high, a `rx_pause_valid` pulse with quantum Q holds `pause_hold` high for Q x CYC_PER_QUANTUM cycles (64 by default, one byte per cycle). No data frame starts while it is high.
- R9: A new received pause frame reloads the hold-off timer. A received quantum of 0 clears `pause_hold` on the next cycle.
- R10: With `pause_en` low, received pause frames have no effect on `pause_hold` or on data frames.
- R11: With `full_duplex` low, no frame starts while `crs` or `col` is high, and `rx_allowed` is 0 while a frame is sent. With `full_duplex` high, `crs` and `col` are ignored and `rx_allowed` stays 1.
- R12: A pause frame that has started always runs its full 60 bytes, even if `cmd_halt` or a received pause arrives during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Enable-transmission pulse |
| cmd_halt | input | 1 | Halt-after-current-frame pulse |
| cmd_pause | input | 1 | Send pause frame with programmed quantum |
| cmd_zero_pause | input | 1 | Send pause frame with zero quantum |
| pause_quanta_cfg | input | 16 | Programmed pause quantum |
| station_addr | input | 48 | Source address placed in pause frames |
| pause_en | input | 1 | Honour received pause frames |
| full_duplex | input | 1 | Full-duplex operation |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| rx_pause_valid | input | 1 | Receiver reports a valid pause frame |
| rx_pause_quanta | input | 16 | Quantum of the received pause frame |
| src_valid | input | 1 | Upstream data byte valid |
| src_data | input | 8 | Upstream data byte |
| src_last | input | 1 | Upstream final byte of frame |
| src_ready | output | 1 | Upstream byte accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of transmitted frame |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_enabled | output | 1 | Transmission enabled |
| pause_hold | output | 1 | Received-pause hold-off active |
| rx_allowed | output | 1 | Receiving permitted |

## Verification
The bound checker checks the following on every cycle: a pause frame is handed off as exactly 60 beats, and an open pause frame stays open until its final beat. `tx_enabled` never drops inside a data frame. A simultaneous request pair always launches the zero quantum first. No data frame starts under hold-off or, in half duplex, under carrier or collision. A zero received quantum releases the hold-off. Some behaviour is only visible in the bench scenarios: the exact byte contents of each pause frame, the hold-off length in cycles and its reload, pass-through data integrity, and the single-frame-per-request rule. The same goes for ordering a pending pause behind an in-flight data frame.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    localparam int FRAME_BYTES = 60;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int QUANTA_W    = 16;
    localparam int ADDR_W      = 48;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_CTRL = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } tx_beat_t;

    // Byte at position idx of a flow-control frame (before FCS).
    function automatic logic [7:0] ctrl_frame_byte(
        input logic [IDX_W-1:0]    idx,
        input logic [ADDR_W-1:0]   sa,
        input logic [QUANTA_W-1:0] q
    );
        int i;
        i = int'(idx);
        if (i >= 6 && i <= 11)
            return sa[8*(11-i) +: 8];
        case (i)
            0:       return 8'h01;
            1:       return 8'h80;
            2:       return 8'hC2;
            3:       return 8'h00;
            4:       return 8'h00;
            5:       return 8'h01;
            12:      return 8'h88;
            13:      return 8'h08;
            14:      return 8'h00;
            15:      return 8'h01;
            16:      return q[15:8];
            17:      return q[7:0];
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/tpc_cmd_sched.sv
module tpc_cmd_sched (
    input  logic clk,
    input  logic rst,
    input  logic cmd_start,
    input  logic cmd_halt,
    input  logic cmd_ctrl_q,
    input  logic cmd_ctrl_z,
    input  logic in_data_frame,
    input  logic take_q,
    input  logic take_z,
    output logic run_o,
    output logic data_permit_o,
    output logic pend_q_o,
    output logic pend_z_o
);
    logic run, halt_pend, pend_q, pend_z;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            halt_pend <= 1'b0;
            pend_q    <= 1'b0;
            pend_z    <= 1'b0;
        end else begin
            if (halt_pend && !in_data_frame) begin
                run       <= 1'b0;
                halt_pend <= 1'b0;
            end
            if (cmd_halt)
                halt_pend <= 1'b1;
            if (cmd_start) begin
                run       <= 1'b1;
                halt_pend <= 1'b0;
            end
            if (take_q)     pend_q <= 1'b0;
            if (cmd_ctrl_q) pend_q <= 1'b1;
            if (take_z)     pend_z <= 1'b0;
            if (cmd_ctrl_z) pend_z <= 1'b1;
        end
    end

    assign run_o         = run;
    assign data_permit_o = run & ~halt_pend;
    assign pend_q_o      = pend_q;
    assign pend_z_o      = pend_z;
endmodule

// File: rtl/tpc_holdoff.sv
module tpc_holdoff #(
    parameter int CYC_PER_QUANTUM = 64,
    parameter int QW              = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] load_quanta,
    output logic          hold_o
);
    localparam int SUB_W = $clog2(CYC_PER_QUANTUM > 1 ? CYC_PER_QUANTUM : 2);
    localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(CYC_PER_QUANTUM - 1);

    logic [QW-1:0]    quanta_left;
    logic [SUB_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            quanta_left <= '0;
            sub         <= '0;
        end else if (load) begin
            quanta_left <= load_quanta;
            sub         <= '0;
        end else if (quanta_left != '0) begin
            if (sub == SUB_MAX) begin
                sub         <= '0;
                quanta_left <= quanta_left - 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign hold_o = (quanta_left != '0);
endmodule

// File: rtl/tpc_ctrl_gen.sv
module tpc_ctrl_gen
    import tpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic [QUANTA_W-1:0] launch_quanta,
    input  logic [ADDR_W-1:0]   station_addr,
    input  logic                advance,
    output logic [7:0]          byte_o,
    output logic                last_o,
    output logic [QUANTA_W-1:0] quanta_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    logic [IDX_W-1:0]    idx;
    logic [QUANTA_W-1:0] quanta;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            quanta <= '0;
        end else if (launch) begin
            idx    <= '0;
            quanta <= launch_quanta;
        end else if (advance) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    assign byte_o   = ctrl_frame_byte(idx, station_addr, quanta);
    assign last_o   = (idx == LAST_IDX);
    assign quanta_o = quanta;
endmodule

// File: rtl/tx_pause_ctrl.sv
module tx_pause_ctrl
    import tpc_pkg::*;
#(
    parameter int CYC_PER_QUANTUM = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic        cmd_halt,
    input  logic        cmd_pause,
    input  logic        cmd_zero_pause,
    input  logic [15:0] pause_quanta_cfg,
    input  logic [47:0] station_addr,
    input  logic        pause_en,
    input  logic        full_duplex,
    input  logic        crs,
    input  logic        col,
    input  logic        rx_pause_valid,
    input  logic [15:0] rx_pause_quanta,
    input  logic        src_valid,
    input  logic [7:0]  src_data,
    input  logic        src_last,
    output logic        src_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        tx_enabled,
    output logic        pause_hold,
    output logic        rx_allowed
);
    tx_state_e           state, state_nxt;
    logic                medium_ok, take_q, take_z, start_data;
    logic                data_permit, pend_q, pend_z, run;
    logic [7:0]          ctrl_byte;
    logic                ctrl_last;
    logic [QUANTA_W-1:0] ctrl_quanta;
    tx_beat_t            beat;

    tpc_cmd_sched u_sched (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cmd_halt      (cmd_halt),
        .cmd_ctrl_q    (cmd_pause),
        .cmd_ctrl_z    (cmd_zero_pause),
        .in_data_frame (state == TX_DATA),
        .take_q        (take_q),
        .take_z        (take_z),
        .run_o         (run),
        .data_permit_o (data_permit),
        .pend_q_o      (pend_q),
        .pend_z_o      (pend_z)
    );

    tpc_holdoff #(
        .CYC_PER_QUANTUM (CYC_PER_QUANTUM),
        .QW              (QUANTA_W)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .load        (rx_pause_valid & pause_en),
        .load_quanta (rx_pause_quanta),
        .hold_o      (pause_hold)
    );

    tpc_ctrl_gen u_gen (
        .clk           (clk),
        .rst           (rst),
        .launch        (take_q | take_z),
        .launch_quanta (take_z ? '0 : pause_quanta_cfg),
        .station_addr  (station_addr),
        .advance       ((state == TX_CTRL) & tx_ready),
        .byte_o        (ctrl_byte),
        .last_o        (ctrl_last),
        .quanta_o      (ctrl_quanta)
    );

    always_comb begin
        medium_ok  = full_duplex | ~(crs | col);
        take_z     = (state == TX_IDLE) & medium_ok & pend_z;
        take_q     = (state == TX_IDLE) & medium_ok & pend_q & ~pend_z;
        start_data = (state == TX_IDLE) & medium_ok & ~pend_z & ~pend_q &
                     data_permit & ~pause_hold & src_valid;

        state_nxt = state;
        case (state)
            TX_IDLE: begin
                if (take_z || take_q) state_nxt = TX_CTRL;
                else if (start_data)  state_nxt = TX_DATA;
            end
            TX_DATA: if (src_valid && tx_ready && src_last) state_nxt = TX_IDLE;
            TX_CTRL: if (tx_ready && ctrl_last)             state_nxt = TX_IDLE;
            default: state_nxt = TX_IDLE;
        endcase

        beat = '0;
        case (state)
            TX_DATA: beat = '{valid: src_valid, data: src_data, last: src_last};
            TX_CTRL: beat = '{valid: 1'b1, data: ctrl_byte, last: ctrl_last};
            default: beat = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= state_nxt;
    end

    assign tx_valid   = beat.valid;
    assign tx_data    = beat.data;
    assign tx_last    = beat.last;
    assign src_ready  = (state == TX_DATA) & tx_ready;
    assign tx_enabled = run;
    assign rx_allowed = full_duplex | (state == TX_IDLE);
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker
    import tpc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        full_duplex,
    input logic        crs,
    input logic        col,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last,
    input logic        rx_allowed,
    input logic        tx_enabled,
    input logic        pause_hold,
    input logic        pause_en,
    input logic        rx_pause_valid,
    input logic [15:0] rx_pause_quanta,
    input tx_state_e   state,
    input logic        pend_q,
    input logic        pend_z,
    input logic [15:0] ctrl_quanta
);
    logic [6:0] beats;

    always_ff @(posedge clk) begin
        if (rst)
            beats <= '0;
        else if (state == TX_CTRL && tx_valid && tx_ready)
            beats <= tx_last ? '0 : beats + 1'b1;
    end

    a_r4_ctrl_length: assert property (@(posedge clk) disable iff (rst)
        (state == TX_CTRL && tx_valid && tx_ready && tx_last) |-> beats == 7'(FRAME_BYTES - 1));

    a_r12_ctrl_completes: assert property (@(posedge clk) disable iff (rst)
        (state == TX_CTRL && !(tx_ready && tx_last)) |=> state == TX_CTRL);

    a_r3_no_cut: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_enabled) |-> state != TX_DATA);

    a_r7_zero_first: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && pend_z && pend_q && (full_duplex || !(crs || col)))
        |=> (state == TX_CTRL && ctrl_quanta == 16'h0000));

    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (pause_hold && state == TX_IDLE) |=> state != TX_DATA);

    a_r9_zero_release: assert property (@(posedge clk) disable iff (rst)
        (pause_en && rx_pause_valid && rx_pause_quanta == 16'h0000) |=> !pause_hold);

    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        (!pause_en && !pause_hold) |=> !pause_hold);

    a_r11_defer: assert property (@(posedge clk) disable iff (rst)
        (!full_duplex && (crs || col) && state == TX_IDLE) |=> state == TX_IDLE);

    a_r11_rx_block: assert property (@(posedge clk) disable iff (rst)
        (!full_duplex && tx_valid) |-> !rx_allowed);
endmodule

bind tx_pause_ctrl tpc_checker u_tpc_checker (
    .clk             (clk),
    .rst             (rst),
    .full_duplex     (full_duplex),
    .crs             (crs),
    .col             (col),
    .tx_valid        (tx_valid),
    .tx_ready        (tx_ready),
    .tx_last         (tx_last),
    .rx_allowed      (rx_allowed),
    .tx_enabled      (tx_enabled),
    .pause_hold      (pause_hold),
    .pause_en        (pause_en),
    .rx_pause_valid  (rx_pause_valid),
    .rx_pause_quanta (rx_pause_quanta),
    .state           (state),
    .pend_q          (pend_q),
    .pend_z          (pend_z),
    .ctrl_quanta     (ctrl_quanta)
);

// File: tb/test_tx_pause_ctrl.sv
module test_tx_pause_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start, cmd_halt, cmd_pause, cmd_zero_pause;
    logic [15:0] pause_quanta_cfg;
    logic [47:0] station_addr;
    logic        pause_en, full_duplex, crs, col;
    logic        rx_pause_valid;
    logic [15:0] rx_pause_quanta;
    logic        src_valid, src_last, src_ready;
    logic [7:0]  src_data;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        tx_enabled, pause_hold, rx_allowed;

    int checks   = 0;
    int failures = 0;

    logic [7:0] cap [0:127];
    logic       cap_rx [0:127];
    int         cap_n;

    always #4 clk = ~clk;

    tx_pause_ctrl i_tx_pause_ctrl (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_halt(cmd_halt),
        .cmd_pause(cmd_pause), .cmd_zero_pause(cmd_zero_pause),
        .pause_quanta_cfg(pause_quanta_cfg), .station_addr(station_addr),
        .pause_en(pause_en), .full_duplex(full_duplex), .crs(crs), .col(col),
        .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready),
        .tx_enabled(tx_enabled), .pause_hold(pause_hold), .rx_allowed(rx_allowed)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic logic [7:0] want_byte(input int i, input logic [15:0] q);
        case (i)
            0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
            3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
            6: return station_addr[47:40];  7: return station_addr[39:32];
            8: return station_addr[31:24];  9: return station_addr[23:16];
            10: return station_addr[15:8];  11: return station_addr[7:0];
            12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
            16: return q[15:8]; 17: return q[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic pulse_rx(input logic [15:0] q);
        @(negedge clk); rx_pause_valid = 1'b1; rx_pause_quanta = q;
        @(negedge clk); rx_pause_valid = 1'b0;
    endtask

    // Capture one transmitted frame, sampled at negedges.
    task automatic grab_frame();
        int waitc = 0;
        cap_n = 0;
        while (!tx_valid && waitc < 400) begin
            @(negedge clk); waitc++;
        end
        while (tx_valid && cap_n < 128) begin
            cap[cap_n] = tx_data; cap_rx[cap_n] = rx_allowed; cap_n++;
            if (tx_last) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_ctrl(input string req, input logic [15:0] q);
        int bad = 0;
        grab_frame();
        chk(req, "pause frame length", cap_n, 60);
        for (int i = 0; i < cap_n && i < 60; i++)
            if (cap[i] !== want_byte(i, q)) bad++;
        chk(req, "pause frame byte mismatches", bad, 0);
        chk(req, "quantum high byte", cap[16], q[15:8]);
        chk(req, "quantum low byte", cap[17], q[7:0]);
    endtask

    // Push one data frame and check it passes unchanged.
    task automatic send_data(input string req, input int n, input logic [7:0] base,
                             input int halt_at, input int ctrl_at);
        int i = 0, cyc = 0, bad = 0, lastpos = -1;
        while (i < n && cyc < 500) begin
            @(negedge clk);
            cmd_halt = 1'b0; cmd_pause = 1'b0;
            src_valid = 1'b1; src_data = base + 8'(i); src_last = (i == n - 1);
            #1;
            if (src_ready) begin
                if (tx_data !== base + 8'(i) || !tx_valid) bad++;
                if (tx_last) lastpos = i;
                if (i == halt_at) cmd_halt = 1'b1;
                if (i == ctrl_at) cmd_pause = 1'b1;
                i++;
            end
            cyc++;
        end
        @(negedge clk);
        cmd_halt = 1'b0; cmd_pause = 1'b0;
        src_valid = 1'b0; src_last = 1'b0;
        chk(req, "data bytes forwarded", i, n);
        chk(req, "data byte mismatches", bad, 0);
        chk(req, "data last position", lastpos, n - 1);
    endtask

    task automatic t_reset();
        chk("R1", "tx_valid after reset", tx_valid, 0);
        chk("R1", "tx_enabled after reset", tx_enabled, 0);
        chk("R1", "pause_hold after reset", pause_hold, 0);
        chk("R1", "rx_allowed after reset", rx_allowed, 1);
    endtask

    task automatic t_start_and_queue();
        pulse(cmd_start);
        chk("R2", "tx_enabled after start", tx_enabled, 1);
        send_data("R2", 6, 8'h30, -1, 2);
        check_ctrl("R6", pause_quanta_cfg);
    endtask

    task automatic t_zero_cmd();
        pulse(cmd_zero_pause);
        check_ctrl("R5", 16'h0000);
    endtask

    task automatic t_both_pending();
        int extra = 0;
        @(negedge clk); cmd_pause = 1'b1; cmd_zero_pause = 1'b1;
        @(negedge clk); cmd_pause = 1'b0; cmd_zero_pause = 1'b0;
        check_ctrl("R7", 16'h0000);
        check_ctrl("R7", pause_quanta_cfg);
        for (int k = 0; k < 80; k++) begin
            @(negedge clk); if (tx_valid) extra++;
        end
        chk("R7", "no extra pause frame", extra, 0);
    endtask

    task automatic t_halt();
        int leaks = 0;
        send_data("R3", 8, 8'h10, 3, -1);
        repeat (3) @(negedge clk);
        chk("R3", "tx_enabled after halt", tx_enabled, 0);
        src_valid = 1'b1; src_data = 8'hEE; src_last = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); if (tx_valid) leaks++;
        end
        src_valid = 1'b0; src_last = 1'b0;
        chk("R3", "data sent while halted", leaks, 0);
    endtask

    task automatic count_hold(output int n, output int leaks);
        n = 0; leaks = 0;
        while (pause_hold && n < 2000) begin
            n++; if (tx_valid) leaks++;
            @(negedge clk);
        end
    endtask

    task automatic t_hold();
        int n, leaks;
        pause_en = 1'b1;
        pulse(cmd_start);
        pulse_rx(16'd2);
        src_valid = 1'b1; src_data = 8'h5A; src_last = 1'b1;
        count_hold(n, leaks);
        chk("R8", "hold cycles for quantum 2", n, 128);
        chk("R8", "data during hold", leaks, 0);
        @(negedge clk);
        chk("R8", "data after hold valid", tx_valid, 1);
        chk("R8", "data after hold byte", tx_data, 8'h5A);
        src_valid = 1'b0; src_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reload();
        int n, leaks;
        pulse_rx(16'd5);
        repeat (10) @(negedge clk);
        pulse_rx(16'd3);
        count_hold(n, leaks);
        chk("R9", "hold cycles after reload", n, 192);
        pulse_rx(16'd4);
        chk("R9", "hold set by quantum 4", pause_hold, 1);
        pulse_rx(16'd0);
        chk("R9", "zero quantum releases hold", pause_hold, 0);
    endtask

    task automatic t_disabled();
        pause_en = 1'b0;
        pulse_rx(16'd7);
        chk("R10", "hold with pause disabled", pause_hold, 0);
        send_data("R10", 2, 8'h70, -1, -1);
    endtask

    task automatic t_half_duplex();
        int leaks = 0, rxbad = 0;
        full_duplex = 1'b0; crs = 1'b1;
        pulse(cmd_zero_pause);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); if (tx_valid) leaks++; if (!rx_allowed) rxbad++;
        end
        chk("R11", "frame started under carrier", leaks, 0);
        chk("R11", "rx blocked while idle", rxbad, 0);
        crs = 1'b0;
        check_ctrl("R11", 16'h0000);
        rxbad = 0;
        for (int i = 0; i < cap_n; i++) if (cap_rx[i]) rxbad++;
        chk("R11", "rx allowed during half-duplex send", rxbad, 0);
        full_duplex = 1'b1; crs = 1'b1; col = 1'b1;
        pulse(cmd_zero_pause);
        check_ctrl("R11", 16'h0000);
        rxbad = 0;
        for (int i = 0; i < cap_n; i++) if (!cap_rx[i]) rxbad++;
        chk("R11", "rx blocked in full duplex", rxbad, 0);
        crs = 1'b0; col = 1'b0;
    endtask

    task automatic t_ctrl_survives();
        int beats = 0, waitc = 0;
        pause_en = 1'b1;
        pulse(cmd_start);
        pulse(cmd_pause);
        while (!tx_valid && waitc < 100) begin @(negedge clk); waitc++; end
        while (tx_valid && beats < 128) begin
            beats++;
            if (beats == 5) begin
                cmd_halt = 1'b1; rx_pause_valid = 1'b1; rx_pause_quanta = 16'h0100;
            end else begin
                cmd_halt = 1'b0; rx_pause_valid = 1'b0;
            end
            if (tx_last) break;
            @(negedge clk);
        end
        @(negedge clk);
        cmd_halt = 1'b0; rx_pause_valid = 1'b0;
        chk("R12", "pause frame beats under halt and rx pause", beats, 60);
        chk("R12", "hold loaded by rx pause", pause_hold, 1);
        chk("R3", "halt after pause frame", tx_enabled, 0);
        pulse(cmd_zero_pause);
        check_ctrl("R6", 16'h0000);
        pulse_rx(16'd0);
        pause_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_start = 0; cmd_halt = 0; cmd_pause = 0; cmd_zero_pause = 0;
        pause_quanta_cfg = 16'hABCD; station_addr = 48'h02_11_22_33_44_55;
        pause_en = 0; full_duplex = 1; crs = 0; col = 0;
        rx_pause_valid = 0; rx_pause_quanta = 0;
        src_valid = 0; src_data = 0; src_last = 0; tx_ready = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_and_queue();
        t_zero_cmd();
        t_both_pending();
        t_halt();
        t_hold();
        t_reload();
        t_disabled();
        t_half_duplex();
        t_ctrl_survives();
        summary();
        $finish;
    end
endmodule